// File: doc/BRIEF.md
# IrDA-Capable Serial Transmitter with Graceful Disable

This block serialises bytes taken from a transmit FIFO into asynchronous frames: one start bit of 0, eight data bits least significant first, and one stop bit of 1. Each bit lasts `OSR` ticks of an oversampling strobe, and the block advances only on cycles where that strobe is high. A mode input changes the line coding from plain NRZ to infrared pulse coding. In that coding a 0 bit becomes one short high pulse centred in the bit cell, a 1 bit sends no pulse, and the idle line is low. A second input picks the pulse width: either 3/16 or 1/4 of a bit.

A disable input stops the transmitter from fetching new bytes. A character that has already been loaded still finishes unchanged. Because no reads are issued while the transmitter is disabled, the FIFO in front of it keeps its contents and keeps filling from the host. Those bytes are sent in order once the transmitter is enabled again.

Top module: `irda_uart_tx`

## Requirements
- R1: After reset `busy` and `fifo_rd` are 0, and with IrDA coding off `tx_line` is 1.
- R2: With IrDA coding off, a frame drives the line as follows: a 0 start bit, then the data bits LSB first, then a 1 stop bit. Each bit lasts `OSR` ticks. The line is 1 whenever no frame is being sent.
- R3: `busy` goes high in the cycle after a FIFO read. It stays high until the last tick of the stop bit. A new byte may be read in the cycle after `busy` falls.
- R4: `fifo_rd` is a one-cycle strobe. It is issued only while the transmitter is idle, enabled and the FIFO is non-empty. `fifo_rdata` is captured in that same cycle.
- R5: With IrDA coding on and `irda_wide`=0, a 0 bit (including the start bit) drives the line high for `3*OSR/16` ticks, beginning at tick `(OSR-width)/2` of the bit cell. For `OSR`=16 this is ticks 6 to 8. A 1 bit and the idle line are 0.
- R6: With IrDA coding on and `irda_wide`=1, the pulse for a 0 bit lasts `OSR/4` ticks and begins at tick `(OSR-width)/2`. For `OSR`=16 this is ticks 6 to 9.
- R7: While `tx_disable` is 1 no FIFO read is issued. Bytes written to the FIFO during that time are kept and sent in order after re-enable.
- R8: Raising `tx_disable` while a frame is in progress does not alter or shorten that frame.
- R9: On cycles where `tick` is 0, the frame position does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling strobe, `OSR` per bit |
| fifo_empty | input | 1 | Transmit FIFO has no data |
| fifo_rdata | input | 8 | Head of FIFO (first-word fall-through) |
| fifo_rd | output | 1 | Pop strobe to the FIFO |
| irda_en | input | 1 | 1 selects infrared pulse coding |
| irda_wide | input | 1 | Pulse width: 0 selects 3/16 of a bit, 1 selects 1/4 of a bit |
| tx_disable | input | 1 | 1 stops fetching new bytes |
| tx_line | output | 1 | Serial output |
| busy | output | 1 | A frame is being shifted |

## Verification
Two events can land on the same clock edge. One is the end of a frame, which frees the shifter for the next fetch. The other is a change of `tx_disable`, which decides whether that fetch may happen. The bench provokes this in two ways. It raises the disable input exactly on the cycle `busy` falls while the FIFO still holds data. It also raises the disable input in the same cycle that a write makes an empty FIFO non-empty. In both cases a behavioural model, updated every clock, decides whether a read is allowed. Every cycle the bench compares `fifo_rd`, `busy` and `tx_line` against that model. It also confirms that the held bytes leave later in their original order.

// File: rtl/irda_uart_tx.sv
module irda_uart_tx #(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_rdata,
  output logic              fifo_rd,
  input  logic              irda_en,
  input  logic              irda_wide,
  input  logic              tx_disable,
  output logic              tx_line,
  output logic              busy
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(OSR);
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int W_NARROW = (3 * OSR) / 16;
  localparam int W_WIDE   = OSR / 4;
  localparam int S_NARROW = (OSR - W_NARROW) / 2;
  localparam int S_WIDE   = (OSR - W_WIDE) / 2;

  logic               busy_q;
  logic [FRAME_W-1:0] sh_q;
  logic [IDX_W-1:0]   idx_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               last_tick;
  logic               in_pulse;
  int                 p_start, p_width;

  assign fifo_rd   = !busy_q && !fifo_empty && !tx_disable;
  assign last_tick = tick && (cnt_q == CNT_W'(OSR - 1));
  assign busy      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (fifo_rd) begin
      busy_q <= 1'b1;
      sh_q   <= {1'b1, fifo_rdata, 1'b0};
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (busy_q && tick) begin
      if (last_tick) begin
        cnt_q <= '0;
        sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
        if (idx_q == IDX_W'(FRAME_W - 1)) busy_q <= 1'b0;
        else idx_q <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    p_start  = irda_wide ? S_WIDE : S_NARROW;
    p_width  = irda_wide ? W_WIDE : W_NARROW;
    in_pulse = (int'(cnt_q) >= p_start) && (int'(cnt_q) < p_start + p_width);
  end

  assign tx_line = irda_en ? (busy_q && !sh_q[0] && in_pulse)
                           : (!busy_q || sh_q[0]);
endmodule

// File: rtl/irda_uart_tx_chk.sv
module irda_uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic fifo_rd,
  input logic irda_en,
  input logic irda_wide,
  input logic tx_disable,
  input logic tx_line,
  input logic busy
);
  // R3
  rd_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> busy);
  // R7
  disabled_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_disable && !busy) |=> !busy);
  // R9
  no_tick_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy);
  // R2
  nrz_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irda_en && !busy) |-> tx_line);
  // R5
  irda_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irda_en && !busy) |-> !tx_line);
  // R6
  wide_pulse_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irda_en && irda_wide && tx_line) |-> busy);
endmodule

bind irda_uart_tx irda_uart_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .fifo_rd(fifo_rd),
  .irda_en(irda_en), .irda_wide(irda_wide), .tx_disable(tx_disable),
  .tx_line(tx_line), .busy(busy)
);

// File: tb/tb_irda_uart_tx.sv
module tb_irda_uart_tx;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, fifo_empty = 1'b1;
  logic [7:0] fifo_rdata = '0;
  logic irda_en = 1'b0, irda_wide = 1'b0, tx_disable = 1'b0;
  logic fifo_rd, tx_line, busy;

  irda_uart_tx dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fifo_empty(fifo_empty),
    .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd), .irda_en(irda_en),
    .irda_wide(irda_wide), .tx_disable(tx_disable), .tx_line(tx_line),
    .busy(busy)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, tdiv = 1;
  logic n_irda = 0, n_wide = 0, n_dis = 0;
  logic [7:0] q[$];
  logic [7:0] pend[$];
  int m_busy = 0, m_bit = 0, m_tick = 0;
  logic [9:0] m_frame = '1;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic step();
    logic ex_rd, ex_tx, b;
    int w;
    @(negedge clk);
    irda_en = n_irda; irda_wide = n_wide; tx_disable = n_dis;
    tick = (tdiv <= 1) || (cyc % tdiv == 0);
    cyc++;
    fifo_empty = (q.size() == 0);
    fifo_rdata = (q.size() != 0) ? q[0] : 8'h00;
    #1;
    b = m_frame[m_bit];
    ex_rd = (m_busy == 0) && !n_dis && (q.size() != 0);
    w = n_wide ? 4 : 3;
    if (n_irda) ex_tx = (m_busy != 0) && !b && (m_tick >= 6) && (m_tick < 6 + w);
    else        ex_tx = (m_busy != 0) ? b : 1'b1;
    chk(fifo_rd == ex_rd, n_dis ? "R7" : "R4", int'(fifo_rd), int'(ex_rd));
    chk(busy == (m_busy != 0), "R3", int'(busy), m_busy);
    chk(tx_line == ex_tx, n_irda ? (n_wide ? "R6" : "R5") : "R2", int'(tx_line), int'(ex_tx));
    if (ex_rd) begin
      m_busy = 1; m_bit = 0; m_tick = 0;
      m_frame = {1'b1, q.pop_front(), 1'b0};
    end else if (m_busy != 0 && tick) begin
      if (m_tick == 15) begin
        m_tick = 0;
        if (m_bit == 9) m_busy = 0; else m_bit++;
      end else m_tick++;
    end
    while (pend.size() != 0) begin
      if (q.size() < 16) q.push_back(pend.pop_front());
      else void'(pend.pop_front());
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 0, "R1", busy, 0);
    chk(fifo_rd == 0, "R1", fifo_rd, 0);
    chk(tx_line == 1, "R1", tx_line, 1);
    rst_n = 1'b1;
    run(3);

    // R2 back-to-back frames, tick every cycle
    pend.push_back(8'hA5); pend.push_back(8'h3C);
    run(360);
    // R9 sparse ticks
    tdiv = 3;
    pend.push_back(8'h00); pend.push_back(8'hFF);
    run(1000);
    tdiv = 1;
    // R5 narrow infrared pulses
    n_irda = 1; n_wide = 0;
    pend.push_back(8'h55); pend.push_back(8'h0F);
    run(350);
    chk(tx_line == 0, "R5", tx_line, 0);
    // R6 wide infrared pulses
    n_wide = 1;
    pend.push_back(8'h96);
    run(180);
    n_irda = 0; n_wide = 0;
    run(2);

    // R8 disable raised mid-frame; R7 FIFO fills while disabled
    pend.push_back(8'hC3);
    run(20);
    chk(busy == 1, "R8", busy, 1);
    n_dis = 1;
    pend.push_back(8'h11); pend.push_back(8'h22); pend.push_back(8'h33);
    run(200);
    chk(busy == 0, "R8", busy, 0);
    chk(q.size() == 3, "R7", q.size(), 3);
    n_dis = 0;
    run(520);
    chk(q.size() == 0, "R7", q.size(), 0);

    // disable lands on the cycle the frame ends, FIFO still holding data
    pend.push_back(8'h81); pend.push_back(8'h7E);
    run(2);
    while (!(m_busy != 0 && m_bit == 9 && m_tick == 15)) step();
    n_dis = 1;
    run(30);
    chk(q.size() == 1, "R7", q.size(), 1);
    chk(busy == 0, "R7", busy, 0);
    n_dis = 0;
    run(180);

    // disable rises as a write makes the FIFO non-empty
    run(5);
    n_dis = 1; pend.push_back(8'h5A);
    run(10);
    chk(busy == 0, "R7", busy, 0);
    n_dis = 0;
    run(180);
    chk(q.size() == 0, "R4", q.size(), 0);
    report();
  end
endmodule